// File: doc/BRIEF.md
# NAND Page ECC Syndrome Decoder and Single-Bit Corrector

This block takes two 24-bit Hamming-style check codes for one 256-byte block of flash data: the code that was written alongside the data, and the code recomputed from the data as it was read back. It forms the bitwise difference of the two codes, called the syndrome, and sorts it into one of four outcomes. The outcomes are: clean; a single flipped data bit that can be repaired; a fault in the stored check code itself; or damage that cannot be repaired. For the repairable case it reports which byte of the block is bad and which bit inside that byte.

A caller raises `req` for one cycle with both codes present. One cycle later `rsp_valid` pulses and the classification, location and suggested code to keep are presented. These results stay on the outputs until the next request. A small read-modify port lets the caller pass the faulty byte through the block. While the held outcome is the repairable case, the byte comes back with the located bit inverted. In every other case it comes back untouched. A two-state controller (WAIT, REPLY) drives the strobe. WAIT goes to REPLY on a request and REPLY returns to WAIT without one. REPLY stays in REPLY on a back-to-back request.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: Every cycle with `req` high produces `rsp_valid` high in the following cycle. A cycle without `req` produces `rsp_valid` low in the following cycle.
- R2: A syndrome of all zeros reports status 0 (clean) with `err_addr` and `err_bit` both 0.
- R3: The ECC bytes are taken as byte0 = bits [7:0], byte1 = bits [15:8] and byte2 = bits [23:16], and the syndrome is computed XOR stored. The error is repairable (status 1) when three conditions all hold. In byte0, bit pairs (7,6), (5,4), (3,2) and (1,0) each differ. In byte1, the same four pairs each differ. In byte2, pairs (7,6), (5,4) and (3,2) each differ, and byte2 bits 1 and 0 are ignored.
- R4: For status 1, `err_addr[7:4]` = byte0 syndrome bits 7,5,3,1 and `err_addr[3:0]` = byte1 syndrome bits 7,5,3,1, with the most significant bit first. `err_bit[2:0]` = byte2 syndrome bits 7,5,3.
- R5: When R3 fails but exactly one of the 24 syndrome bits is set, status is 2 (stored code faulty). In that case `code_out` carries the computed code.
- R6: Any other nonzero syndrome reports status 3 (uncorrectable). For statuses 0, 1 and 3, `code_out` carries the stored code. For statuses other than 1, `err_addr` and `err_bit` are 0.
- R7: While the held status is 1, `fix_out` equals `fix_in` with bit `err_bit` inverted.
- R8: While the held status is not 1, `fix_out` equals `fix_in`.
- R9: After reset, status, `err_addr`, `err_bit` and `code_out` are 0 and `rsp_valid` is low. Results hold their values until the next request, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one decode per high cycle |
| ecc_calc | input | 24 | Code recomputed from the read data |
| ecc_stored | input | 24 | Code read from the spare area |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| status | output | 2 | 0 clean, 1 data bit repairable, 2 stored code faulty, 3 uncorrectable |
| err_addr | output | 8 | Byte offset of the bad bit |
| err_bit | output | 3 | Bit position inside the bad byte |
| code_out | output | 24 | Code the caller should keep |
| fix_in | input | 8 | Data byte presented for repair |
| fix_out | output | 8 | Repaired or untouched data byte |

## Verification
Suppose the pair test or the popcount misjudges a syndrome. The fault then appears as a wrong status exactly one cycle after the request, on the first `rsp_valid` pulse. If the location mapping is swapped or shifted, the address or bit output is wrong in that same cycle. The same error also appears as the wrong bit inverted on `fix_out` for as long as the result is held. A controller stuck in REPLY, or one that never leaves WAIT, shows up as a `rsp_valid` level that is wrong one cycle after any request or idle cycle. Result registers that reload without a request show up as a status that changes while `req` is low.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = 3;
    localparam int CODE_W   = BYTE_W * N_BYTES;
    localparam int ADDR_W   = 8;
    localparam int BITSEL_W = 3;
    localparam int PAIRS    = BYTE_W / 2;
    localparam int CNT_W    = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        VERDICT_CLEAN    = 2'd0,
        VERDICT_DATA_FIX = 2'd1,
        VERDICT_CODE_BAD = 2'd2,
        VERDICT_FATAL    = 2'd3
    } verdict_t;

    typedef enum logic {
        CTL_WAIT  = 1'b0,
        CTL_REPLY = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
    import ecc_syn_pkg::*;
(
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] kept_code,
    output logic [CODE_W-1:0] synd,
    output logic              pairs_ok,
    output logic              lone_bit,
    output logic              any_bit
);
    logic [N_BYTES*PAIRS-1:0] pair_diff;
    logic [CNT_W-1:0]         ones;

    assign synd = calc_code ^ kept_code;

    // Each complementary pair must disagree; the lowest pair of the last byte is free.
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            if (b == N_BYTES - 1 && p == 0) begin : g_free
                assign pair_diff[b*PAIRS+p] = 1'b1;
            end else begin : g_tied
                assign pair_diff[b*PAIRS+p] = synd[b*BYTE_W+2*p+1] ^ synd[b*BYTE_W+2*p];
            end
        end
    end

    assign pairs_ok = &pair_diff;

    always_comb begin
        ones = '0;
        for (int i = 0; i < CODE_W; i++) begin
            ones = ones + CNT_W'(synd[i]);
        end
    end

    assign lone_bit = (ones == CNT_W'(1));
    assign any_bit  = |synd;
endmodule

// File: rtl/ecc_syn_locate.sv
module ecc_syn_locate
    import ecc_syn_pkg::*;
(
    input  logic [CODE_W-1:0]   synd,
    output logic [ADDR_W-1:0]   byte_pos,
    output logic [BITSEL_W-1:0] bit_pos
);
    localparam int HALF = ADDR_W / 2;

    // Odd bits of the first two bytes give the byte offset, high byte first.
    for (genvar k = 0; k < HALF; k++) begin : g_addr
        assign byte_pos[HALF+k] = synd[2*k+1];
        assign byte_pos[k]      = synd[BYTE_W+2*k+1];
    end

    // Odd bits 3, 5, 7 of the last byte give the bit number.
    for (genvar k = 0; k < BITSEL_W; k++) begin : g_bit
        assign bit_pos[k] = synd[2*BYTE_W+2*k+3];
    end
endmodule

// File: rtl/ecc_syn_flip.sv
module ecc_syn_flip
    import ecc_syn_pkg::*;
(
    input  logic                enable,
    input  logic [BITSEL_W-1:0] bit_pos,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [BYTE_W-1:0]   byte_out
);
    logic [BYTE_W-1:0] mask;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign mask[i] = enable && (bit_pos == BITSEL_W'(i));
    end

    assign byte_out = byte_in ^ mask;
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
    import ecc_syn_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [CODE_W-1:0]   ecc_calc,
    input  logic [CODE_W-1:0]   ecc_stored,
    output logic                rsp_valid,
    output logic [1:0]          status,
    output logic [ADDR_W-1:0]   err_addr,
    output logic [BITSEL_W-1:0] err_bit,
    output logic [CODE_W-1:0]   code_out,
    input  logic [BYTE_W-1:0]   fix_in,
    output logic [BYTE_W-1:0]   fix_out
);
    ctl_state_t state_q, state_d;

    logic [CODE_W-1:0]   synd;
    logic                pairs_ok, lone_bit, any_bit;
    logic [ADDR_W-1:0]   loc_addr;
    logic [BITSEL_W-1:0] loc_bit;
    verdict_t            verdict_d, verdict_q;

    ecc_syn_classify u_class (
        .calc_code (ecc_calc),
        .kept_code (ecc_stored),
        .synd      (synd),
        .pairs_ok  (pairs_ok),
        .lone_bit  (lone_bit),
        .any_bit   (any_bit)
    );

    ecc_syn_locate u_loc (
        .synd     (synd),
        .byte_pos (loc_addr),
        .bit_pos  (loc_bit)
    );

    always_comb begin
        if (!any_bit)      verdict_d = VERDICT_CLEAN;
        else if (pairs_ok) verdict_d = VERDICT_DATA_FIX;
        else if (lone_bit) verdict_d = VERDICT_CODE_BAD;
        else               verdict_d = VERDICT_FATAL;
    end

    // Controller: WAIT -> REPLY on request, REPLY -> WAIT without one.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_WAIT:  state_d = req ? CTL_REPLY : CTL_WAIT;
            CTL_REPLY: state_d = req ? CTL_REPLY : CTL_WAIT;
            default:   state_d = CTL_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_WAIT;
        else        state_q <= state_d;
    end

    // Result registers load only on a request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= VERDICT_CLEAN;
            err_addr  <= '0;
            err_bit   <= '0;
            code_out  <= '0;
        end else if (req) begin
            verdict_q <= verdict_d;
            err_addr  <= (verdict_d == VERDICT_DATA_FIX) ? loc_addr : '0;
            err_bit   <= (verdict_d == VERDICT_DATA_FIX) ? loc_bit  : '0;
            code_out  <= (verdict_d == VERDICT_CODE_BAD) ? ecc_calc : ecc_stored;
        end
    end

    assign rsp_valid = (state_q == CTL_REPLY);
    assign status    = verdict_q;

    ecc_syn_flip u_flip (
        .enable   (verdict_q == VERDICT_DATA_FIX),
        .bit_pos  (err_bit),
        .byte_in  (fix_in),
        .byte_out (fix_out)
    );
endmodule

module ecc_syn_checker
    import ecc_syn_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req,
    input logic [CODE_W-1:0]   ecc_calc,
    input logic [CODE_W-1:0]   ecc_stored,
    input logic                rsp_valid,
    input logic [1:0]          status,
    input logic [ADDR_W-1:0]   err_addr,
    input logic [BITSEL_W-1:0] err_bit,
    input logic [CODE_W-1:0]   code_out,
    input logic [BYTE_W-1:0]   fix_in,
    input logic [BYTE_W-1:0]   fix_out
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid); // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid); // R1
    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ecc_calc == ecc_stored) |=> (status == 2'd0 && err_addr == '0 && err_bit == '0)); // R2
    AST_LONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $countones(ecc_calc ^ ecc_stored) == 1) |=> (status == 2'd2 && code_out == $past(ecc_calc))); // R5
    AST_FIX_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1) |-> ($countones(fix_out ^ fix_in) == 1)); // R7
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd1) |-> (fix_out == fix_in)); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(status) && $stable(err_addr) && $stable(code_out))); // R9
endmodule

bind ecc_syndrome_corrector ecc_syn_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ecc_calc   (ecc_calc),
    .ecc_stored (ecc_stored),
    .rsp_valid  (rsp_valid),
    .status     (status),
    .err_addr   (err_addr),
    .err_bit    (err_bit),
    .code_out   (code_out),
    .fix_in     (fix_in),
    .fix_out    (fix_out)
);

// File: tb/sim_ecc_syndrome_corrector.sv
module sim_ecc_syndrome_corrector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] ecc_calc = '0;
    logic [23:0] ecc_stored = '0;
    logic        rsp_valid;
    logic [1:0]  status;
    logic [7:0]  err_addr;
    logic [2:0]  err_bit;
    logic [23:0] code_out;
    logic [7:0]  fix_in = 8'h00;
    logic [7:0]  fix_out;

    int n_run = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ecc_syndrome_corrector u0 (
        .clk(clk), .rst_n(rst_n), .req(req),
        .ecc_calc(ecc_calc), .ecc_stored(ecc_stored),
        .rsp_valid(rsp_valid), .status(status),
        .err_addr(err_addr), .err_bit(err_bit), .code_out(code_out),
        .fix_in(fix_in), .fix_out(fix_out)
    );

    // {computed code, syndrome, status, address, bit}
    localparam int NV = 12;
    localparam logic [60:0] VEC [0:NV-1] = '{
        {24'h3CA501, 24'h000000, 2'd0, 8'h00, 3'd0},
        {24'h000000, 24'h545555, 2'd1, 8'h00, 3'd0},
        {24'hFFFFFF, 24'hA8AAAA, 2'd1, 8'hFF, 3'd7},
        {24'h5A5A5A, 24'h986699, 2'd1, 8'hA5, 3'd5},
        {24'h123456, 24'h64A55A, 2'd1, 8'h3C, 3'd2},
        {24'h0F0F0F, 24'h575555, 2'd1, 8'h00, 3'd0},
        {24'hABCDEF, 24'h000001, 2'd2, 8'h00, 3'd0},
        {24'h00FF00, 24'h800000, 2'd2, 8'h00, 3'd0},
        {24'h777777, 24'h000100, 2'd2, 8'h00, 3'd0},
        {24'h246801, 24'h000003, 2'd3, 8'h00, 3'd0},
        {24'h135790, 24'h545554, 2'd3, 8'h00, 3'd0},
        {24'h000000, 24'hFFFFFF, 2'd3, 8'h00, 3'd0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        // Reset state (R9, R8)
        fix_in = 8'h5A;
        repeat (2) @(negedge clk);
        chk(status == 2'd0, "R9 reset status", 32'(status), 0);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 0);
        chk(code_out == 24'h0, "R9 reset code_out", 32'(code_out), 0);
        chk(fix_out == 8'h5A, "R8 reset passthrough", 32'(fix_out), 32'h5A);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle after reset", 32'(rsp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] base, syn, exp_code;
            logic [1:0]  est;
            logic [7:0]  ea, efix;
            logic [2:0]  eb;
            {base, syn, est, ea, eb} = VEC[i];
            exp_code = (est == 2'd2) ? base : (base ^ syn);
            efix = (est == 2'd1) ? (8'hC3 ^ (8'h01 << eb)) : 8'hC3;
            ecc_calc = base; ecc_stored = base ^ syn; fix_in = 8'hC3; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk(rsp_valid == 1'b1, "R1 rsp_valid after req", 32'(rsp_valid), 1);
            chk(status == est, "R2/R3/R5/R6 status", 32'(status), 32'(est));
            chk(err_addr == ea, "R4 err_addr", 32'(err_addr), 32'(ea));
            chk(err_bit == eb, "R4 err_bit", 32'(err_bit), 32'(eb));
            chk(code_out == exp_code, "R5/R6 code_out", 32'(code_out), 32'(exp_code));
            chk(fix_out == efix, "R7/R8 fix_out", 32'(fix_out), 32'(efix));
            ecc_calc = 24'h9E3779; ecc_stored = 24'h000001;
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R1 strobe drops", 32'(rsp_valid), 0);
            chk(status == est, "R9 status held", 32'(status), 32'(est));
            chk(code_out == exp_code, "R9 code held", 32'(code_out), 32'(exp_code));
        end

        // Back-to-back requests (R1)
        ecc_calc = 24'h0; ecc_stored = 24'hA8AAAA; req = 1'b1; fix_in = 8'h00;
        @(negedge clk);
        ecc_calc = 24'h0; ecc_stored = 24'h000010;
        chk(rsp_valid && status == 2'd1, "R1 first of pair", 32'(status), 1);
        chk(fix_out == 8'h80, "R7 bit7 flip", 32'(fix_out), 32'h80);
        @(negedge clk);
        req = 1'b0;
        chk(rsp_valid && status == 2'd2, "R1 second of pair", 32'(status), 2);
        chk(code_out == 24'h0, "R5 computed code kept", 32'(code_out), 0);
        chk(fix_out == 8'h00, "R8 no flip status2", 32'(fix_out), 0);

        // Reset with repair result held (R9)
        ecc_calc = 24'h0; ecc_stored = 24'h986699; req = 1'b1; fix_in = 8'hFF;
        @(negedge clk);
        req = 1'b0;
        chk(fix_out == 8'hDF, "R7 bit5 flip", 32'(fix_out), 32'hDF);
        rst_n = 1'b0;
        @(negedge clk);
        chk(status == 2'd0 && err_addr == 8'h0, "R9 reset clears", 32'(status), 0);
        chk(fix_out == 8'hFF, "R8 passthrough after reset", 32'(fix_out), 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule